// File: doc/BRIEF.md
# Parallel EEPROM page-write controller

This block sits on the host side of a byte-wide parallel nonvolatile memory. It drives the memory's active-low chip-enable, output-enable and write-enable strobes, a 13-bit address bus and an 8-bit data bus. The data bus is split into an outgoing byte, an incoming byte and a separate drive enable for the pad tristate. The host fills a 64-entry page buffer, then requests a page write of 1 to 64 bytes. The controller issues one write strobe per byte, with a short fixed gap between bytes so the memory keeps its page window open. It then finds the end of the memory's self-timed internal write by reading twice in a row and comparing data bit 6.

A single-byte read of any address is also available. Both operations use a start / busy / done handshake. After reset the controller stays busy for a configurable number of clocks, so the memory has time to power up before it is accessed. If bit 6 keeps toggling for more than a set number of polls, the controller gives up and raises an error flag with its done pulse.

Top module: `eeprom_page_ctl`

## Requirements
- R1: After reset `busy` is high for `PWRUP_CYC` clocks with all three strobes high and `memDoutEn` low. A `startWr` or `startRd` during that time has no effect: no memory cycle is issued and nothing is written.
- R2: A page write stores buffer entry i at address {pageAddr[12:6], (pageAddr[5:0]+i) mod 64}, for i from 0. Every byte of one write shares pageAddr[12:6]. Each byte has chip-enable low, output-enable high and write-enable low for `WR_PULSE` clocks, and `memDoutEn` is high whenever write-enable is low.
- R3: Output-enable and write-enable are never low together, and `memDoutEn` is never high while output-enable is low.
- R4: `byteCount` gives the number of bytes to write, and the value 0 means 64. Addresses beyond the requested count are not written.
- R5: Between two byte strobes of one page, write-enable stays high for at most `GAP_CYC`+2 clocks. Chip-enable is high for `GAP_CYC` of them.
- R6: After the last byte the controller polls with read cycles. Each poll holds chip-enable and output-enable low for `RD_HOLD` clocks. The write completes when two consecutive polls return the same bit 6; `done` then pulses with `errFlag` low.
- R7: If `MAX_POLLS` consecutive poll comparisons all show bit 6 changed, polling stops after exactly `MAX_POLLS`+1 reads. `done` pulses with `errFlag` high, and `errFlag` stays high until the next accepted start clears it.
- R8: `startRd` reads the byte at `pageAddr` with one read cycle. The byte appears on `rdData` in the cycle `done` pulses.
- R9: `done` is a one-clock pulse and `busy` is low in that cycle. A start presented in the cycle `done` is high is accepted, and `busy` is high in the next cycle.
- R10: Buffer writes through `bufWe` while `busy` is high are ignored. The byte already in the buffer is what reaches the memory.
- R11: A start offset near the end of a page wraps the low 6 address bits back to the page start, and the upper bits stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWr | input | 1 | Request a page write (taken when not busy) |
| startRd | input | 1 | Request a single-byte read (taken when not busy, lower priority than startWr) |
| pageAddr | input | 13 | Start address of the write, or address of the read |
| byteCount | input | 6 | Bytes to write, 0 means 64 |
| bufWe | input | 1 | Page buffer write strobe |
| bufAddr | input | 6 | Page buffer entry |
| bufData | input | 8 | Page buffer write data |
| busy | output | 1 | Operation or power-up hold in progress |
| done | output | 1 | One-clock completion pulse |
| errFlag | output | 1 | Last write ended by poll timeout |
| rdData | output | 8 | Last byte read from the memory |
| memCeN | output | 1 | Memory chip-enable, active low |
| memOeN | output | 1 | Memory output-enable, active low |
| memWeN | output | 1 | Memory write-enable, active low |
| memAddr | output | 13 | Memory address bus |
| memDout | output | 8 | Byte driven toward the memory |
| memDoutEn | output | 1 | Drive enable for the data bus tristate |
| memDin | input | 8 | Byte returned by the memory |

## Verification
The completion pulse of one operation and the acceptance of the next start can fall in the same clock, because `done` and the return to idle coincide. The bench waits for the `done` pulse of a read and raises `startRd` for a new address in that same cycle. In the following cycle it requires `busy` high, and after the second `done` it requires the new byte on `rdData`. A second overlap, a host buffer write landing while the engine is fetching the same entry, is provoked by writing entry 0 during a busy page write. It is judged by reading the memory back, which must hold the byte loaded before the start.

// File: rtl/eeprom_ctl_pkg.sv
package eeprom_ctl_pkg;

  typedef enum logic [3:0] {
    S_PWRUP, S_IDLE, S_WSET, S_WSTB, S_WHLD, S_WGAP, S_PRD, S_PCMP, S_RRD
  } ctlState_t;

  // Strobes sent from the control FSM to the datapath
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic driveEn;
    logic latchReq;
    logic nextByte;
    logic sampleRd;
    logic setRef;
  } ctlStrobes_t;

endpackage

// File: rtl/eeprom_ctl_fsm.sv
module eeprom_ctl_fsm
  import eeprom_ctl_pkg::*;
#(
  parameter int RD_HOLD   = 12,
  parameter int WR_PULSE  = 20,
  parameter int GAP_CYC   = 4,
  parameter int PWRUP_CYC = 1000000,
  parameter int MAX_POLLS = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startWr,
  input  logic        startRd,
  input  logic        lastByte,
  input  logic        bit6Changed,
  output ctlStrobes_t strb,
  output logic        busy,
  output logic        done,
  output logic        errFlag
);

  localparam int T_A    = (RD_HOLD > WR_PULSE) ? RD_HOLD : WR_PULSE;
  localparam int T_B    = (GAP_CYC > T_A) ? GAP_CYC : T_A;
  localparam int T_MAX  = (PWRUP_CYC > T_B) ? PWRUP_CYC : T_B;
  localparam int CNT_W  = $clog2(T_MAX + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  ctlState_t          state, nxt;
  logic [CNT_W-1:0]   waitCnt;
  logic [POLL_W-1:0]  pollCnt;
  logic               firstPoll;
  logic               finOk, finErr;
  logic               tPwr, tStb, tGap, tRd, pollLimit;

  assign tPwr      = (waitCnt == CNT_W'(PWRUP_CYC - 1));
  assign tStb      = (waitCnt == CNT_W'(WR_PULSE - 1));
  assign tGap      = (waitCnt == CNT_W'(GAP_CYC - 1));
  assign tRd       = (waitCnt == CNT_W'(RD_HOLD - 1));
  assign pollLimit = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign busy      = (state != S_IDLE);

  always_comb begin
    nxt    = state;
    strb   = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, default: 1'b0};
    finOk  = 1'b0;
    finErr = 1'b0;
    case (state)
      S_PWRUP: if (tPwr) nxt = S_IDLE;
      S_IDLE: begin
        if (startWr) begin
          strb.latchReq = 1'b1;
          nxt = S_WSET;
        end else if (startRd) begin
          strb.latchReq = 1'b1;
          nxt = S_RRD;
        end
      end
      S_WSET: begin
        strb.ceN = 1'b0;
        strb.driveEn = 1'b1;
        nxt = S_WSTB;
      end
      S_WSTB: begin
        strb.ceN = 1'b0;
        strb.weN = 1'b0;
        strb.driveEn = 1'b1;
        if (tStb) nxt = S_WHLD;
      end
      S_WHLD: begin
        strb.ceN = 1'b0;
        strb.driveEn = 1'b1;
        if (lastByte) nxt = S_PRD;
        else begin
          strb.nextByte = 1'b1;
          nxt = S_WGAP;
        end
      end
      S_WGAP: if (tGap) nxt = S_WSET;
      S_PRD: begin
        strb.ceN = 1'b0;
        strb.oeN = 1'b0;
        if (tRd) begin
          strb.sampleRd = 1'b1;
          nxt = S_PCMP;
        end
      end
      S_PCMP: begin
        if (firstPoll) begin
          strb.setRef = 1'b1;
          nxt = S_PRD;
        end else if (!bit6Changed) begin
          finOk = 1'b1;
          nxt = S_IDLE;
        end else if (pollLimit) begin
          finErr = 1'b1;
          nxt = S_IDLE;
        end else begin
          strb.setRef = 1'b1;
          nxt = S_PRD;
        end
      end
      S_RRD: begin
        strb.ceN = 1'b0;
        strb.oeN = 1'b0;
        if (tRd) begin
          strb.sampleRd = 1'b1;
          finOk = 1'b1;
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_PWRUP;
      waitCnt   <= '0;
      pollCnt   <= '0;
      firstPoll <= 1'b0;
      done      <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state || state == S_IDLE) waitCnt <= '0;
      else waitCnt <= waitCnt + 1'b1;
      done <= finOk | finErr;
      if (strb.latchReq) begin
        pollCnt   <= '0;
        firstPoll <= 1'b1;
        errFlag   <= 1'b0;
      end else if (state == S_PCMP) begin
        firstPoll <= 1'b0;
        if (!firstPoll && bit6Changed && !pollLimit) pollCnt <= pollCnt + 1'b1;
      end
      if (finErr) errFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/eeprom_ctl_datapath.sv
module eeprom_ctl_datapath
  import eeprom_ctl_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 6,
  parameter int TOG_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              busy,
  input  logic [ADDR_W-1:0] pageAddr,
  input  logic [PAGE_W-1:0] byteCount,
  input  logic              bufWe,
  input  logic [PAGE_W-1:0] bufAddr,
  input  logic [DATA_W-1:0] bufData,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData,
  output logic              lastByte,
  output logic              bit6Changed
);

  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0] bufMem [PAGE_BYTES];
  logic [ADDR_W-1:0] addrReg;
  logic [PAGE_W-1:0] cntReg;
  logic [PAGE_W-1:0] idx;
  logic [DATA_W-1:0] rdReg;
  logic              refBit;

  always_ff @(posedge clk) begin
    if (bufWe && !busy) bufMem[bufAddr] <= bufData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      cntReg  <= '0;
      idx     <= '0;
      rdReg   <= '0;
      refBit  <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        addrReg <= pageAddr;
        cntReg  <= byteCount;
        idx     <= '0;
      end else if (strb.nextByte) begin
        idx <= idx + 1'b1;
      end
      if (strb.sampleRd) rdReg <= memDin;
      if (strb.setRef) refBit <= rdReg[TOG_BIT];
    end
  end

  assign memCeN      = strb.ceN;
  assign memOeN      = strb.oeN;
  assign memWeN      = strb.weN;
  assign memDoutEn   = strb.driveEn;
  assign memAddr     = {addrReg[ADDR_W-1:PAGE_W], addrReg[PAGE_W-1:0] + idx};
  assign memDout     = bufMem[idx];
  assign rdData      = rdReg;
  assign lastByte    = (idx == cntReg - 1'b1);
  assign bit6Changed = (rdReg[TOG_BIT] != refBit);

endmodule

// File: rtl/eeprom_page_ctl.sv
module eeprom_page_ctl
  import eeprom_ctl_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 6,
  parameter int TOG_BIT   = 6,
  parameter int RD_HOLD   = 12,
  parameter int WR_PULSE  = 20,
  parameter int GAP_CYC   = 4,
  parameter int PWRUP_CYC = 1000000,
  parameter int MAX_POLLS = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startRd,
  input  logic [ADDR_W-1:0] pageAddr,
  input  logic [PAGE_W-1:0] byteCount,
  input  logic              bufWe,
  input  logic [PAGE_W-1:0] bufAddr,
  input  logic [DATA_W-1:0] bufData,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic [DATA_W-1:0] rdData,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  ctlStrobes_t strb;
  logic        lastByte;
  logic        bit6Changed;

  eeprom_ctl_fsm #(
    .RD_HOLD(RD_HOLD), .WR_PULSE(WR_PULSE), .GAP_CYC(GAP_CYC),
    .PWRUP_CYC(PWRUP_CYC), .MAX_POLLS(MAX_POLLS)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .lastByte(lastByte), .bit6Changed(bit6Changed), .strb(strb),
    .busy(busy), .done(done), .errFlag(errFlag)
  );

  eeprom_ctl_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .TOG_BIT(TOG_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .pageAddr(pageAddr), .byteCount(byteCount),
    .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData), .memDin(memDin),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDout(memDout), .memDoutEn(memDoutEn), .rdData(rdData),
    .lastByte(lastByte), .bit6Changed(bit6Changed)
  );

endmodule

// File: rtl/eeprom_page_ctl_chk.sv
module eeprom_page_ctl_chk #(
  parameter int ADDR_W    = 13,
  parameter int GAP_CYC   = 4,
  parameter int PWRUP_CYC = 1000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              errFlag,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDoutEn,
  input logic [ADDR_W-1:0] memAddr
);

  logic [31:0] upCnt;
  logic [31:0] hiCnt;
  logic        armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upCnt <= '0;
      hiCnt <= '0;
      armed <= 1'b0;
    end else begin
      if (upCnt != 32'hFFFF_FFFF) upCnt <= upCnt + 1'b1;
      if (!memWeN) begin
        hiCnt <= '0;
        armed <= 1'b1;
      end else begin
        if (hiCnt != 32'hFFFF_FFFF) hiCnt <= hiCnt + 1'b1;
        if (!memOeN || !busy) armed <= 1'b0;
      end
    end
  end

  // R1
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt < 32'(PWRUP_CYC)) |-> (busy && memCeN && memWeN));

  // R3
  no_strobe_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  // R3
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN);

  // R2
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDoutEn && !memCeN));

  // R2
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R5
  byte_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && memWeN && memOeN) |-> (hiCnt <= 32'(GAP_CYC + 1)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && memCeN && memOeN && memWeN && !memDoutEn));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> done);

endmodule

bind eeprom_page_ctl eeprom_page_ctl_chk #(
  .ADDR_W(ADDR_W), .GAP_CYC(GAP_CYC), .PWRUP_CYC(PWRUP_CYC)
) chk_i (.*);

// File: tb/eeprom_page_ctl_tb.sv
`timescale 1ns/1ps
module eeprom_page_ctl_tb_top;

  localparam int RD_HOLD   = 3;
  localparam int WR_PULSE  = 3;
  localparam int GAP_CYC   = 2;
  localparam int PWRUP_CYC = 200;
  localparam int MAX_POLLS = 40;

  typedef struct packed {
    logic [12:0] base;
    logic [5:0]  cnt;
    logic [7:0]  seed;
    logic [7:0]  busyReads;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{13'h0040, 6'd4, 8'h11, 8'd5},
    '{13'h1FC0, 6'd0, 8'hA5, 8'd12},
    '{13'h0A3C, 6'd8, 8'h3C, 8'd0},
    '{13'h0555, 6'd1, 8'h7E, 8'd30}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startWr = 1'b0, startRd = 1'b0;
  logic [12:0] pageAddr = '0;
  logic [5:0]  byteCount = '0;
  logic        bufWe = 1'b0;
  logic [5:0]  bufAddr = '0;
  logic [7:0]  bufData = '0;
  logic        busy, done, errFlag;
  logic [7:0]  rdData;
  logic        memCeN, memOeN, memWeN, memDoutEn;
  logic [12:0] memAddr;
  logic [7:0]  memDout, memDin;

  always #2.5 clk = ~clk;

  eeprom_page_ctl #(
    .RD_HOLD(RD_HOLD), .WR_PULSE(WR_PULSE), .GAP_CYC(GAP_CYC),
    .PWRUP_CYC(PWRUP_CYC), .MAX_POLLS(MAX_POLLS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .pageAddr(pageAddr), .byteCount(byteCount), .bufWe(bufWe),
    .bufAddr(bufAddr), .bufData(bufData), .busy(busy), .done(done),
    .errFlag(errFlag), .rdData(rdData), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [int];
  int   busyLeft = 0, nextBusy = 0;
  bit   forceTog = 0, tog = 0;
  logic [7:0] outByte = 8'hFF;
  int   wrCount = 0, rdCount = 0, cyc = 0, lastWrCyc = -1, maxPeriod = 0;
  logic prevOe = 1'b1, prevWe = 1'b1;
  logic [6:0] firstUpper = '0;
  bit   upperSet = 0, pageViol = 0, clashSeen = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (!memOeN && !memWeN) clashSeen = 1;
      if (memDoutEn && !memOeN) clashSeen = 1;
      if (!prevWe && memWeN && !memCeN) begin
        mem[int'(memAddr)] = memDout;
        busyLeft = nextBusy;
        wrCount++;
        if (upperSet && memAddr[12:6] != firstUpper) pageViol = 1;
        firstUpper = memAddr[12:6];
        upperSet = 1;
        if (lastWrCyc >= 0 && cyc - lastWrCyc > maxPeriod) maxPeriod = cyc - lastWrCyc;
        lastWrCyc = cyc;
      end
      if (prevOe && !memOeN && !memCeN) begin
        rdCount++;
        if (forceTog || busyLeft > 0) begin
          if (busyLeft > 0) busyLeft--;
          tog = ~tog;
          outByte = {1'b0, tog, 6'b0};
        end else begin
          outByte = mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'hFF;
        end
      end
    end
    prevOe = memOeN;
    prevWe = memWeN;
  end

  assign memDin = outByte;

  // ---------------- checking helpers ----------------
  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clrModel();
    wrCount = 0; rdCount = 0; upperSet = 0; pageViol = 0;
    lastWrCyc = -1; maxPeriod = 0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      n++;
      if (n > 20000) begin
        chk(0, req, 0, 1);
        break;
      end
    end
  endtask

  task automatic loadBuf(input int i, input logic [7:0] v);
    @(negedge clk);
    bufWe = 1'b1; bufAddr = 6'(i); bufData = v;
    @(negedge clk);
    bufWe = 1'b0;
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [5:0] c);
    clrModel();
    @(negedge clk);
    pageAddr = a; byteCount = c; startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
    waitDone("R6 write done");
  endtask

  task automatic doRead(input logic [12:0] a, output logic [7:0] v);
    @(negedge clk);
    pageAddr = a; startRd = 1'b1;
    @(negedge clk);
    startRd = 1'b0;
    waitDone("R8 read done");
    v = rdData;
  endtask

  function automatic logic [7:0] patByte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] v;
    int waited;
    int nb;
    logic [12:0] a;

    repeat (3) @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDoutEn, "R1 reset pins", {memCeN, memOeN, memWeN, memDoutEn}, 4'b1110);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    // start during power-up hold must be ignored
    pageAddr = 13'h0100; byteCount = 6'd1; startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
    waited = 2;
    while (busy && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited >= PWRUP_CYC - 2 && waited <= PWRUP_CYC + 2, "R1 hold length", waited, PWRUP_CYC);
    chk(wrCount == 0, "R1 no write during hold", wrCount, 0);
    doRead(13'h0100, v);
    chk(v == 8'hFF, "R1 hold start ignored", v, 8'hFF);

    // table-driven page writes
    for (int t = 0; t < 4; t++) begin
      nb = (VECS[t].cnt == 6'd0) ? 64 : int'(VECS[t].cnt);
      for (int i = 0; i < nb; i++) loadBuf(i, patByte(VECS[t].seed, i));
      nextBusy = int'(VECS[t].busyReads);
      doWrite(VECS[t].base, VECS[t].cnt);
      chk(errFlag == 1'b0, "R6 no error", errFlag, 0);
      chk(wrCount == nb, "R4 byte count", wrCount, nb);
      chk(!pageViol, "R2 same page", pageViol, 0);
      chk(maxPeriod <= WR_PULSE + GAP_CYC + 2, "R5 byte spacing", maxPeriod, WR_PULSE + GAP_CYC + 2);
      for (int i = 0; i < nb; i++) begin
        a = {VECS[t].base[12:6], 6'(VECS[t].base[5:0] + 6'(i))};
        doRead(a, v);
        chk(v == patByte(VECS[t].seed, i), (t == 2) ? "R11 wrapped readback" : "R2 readback", v, patByte(VECS[t].seed, i));
      end
    end
    // byte past the requested count stays erased
    doRead(13'h0044, v);
    chk(v == 8'hFF, "R4 beyond count untouched", v, 8'hFF);
    // wrap target must not leak into the next page
    doRead(13'h0A40, v);
    chk(v == 8'hFF, "R11 next page untouched", v, 8'hFF);

    // poll timeout
    forceTog = 1;
    loadBuf(0, 8'h99);
    doWrite(13'h0200, 6'd1);
    chk(errFlag == 1'b1, "R7 timeout flag", errFlag, 1);
    chk(rdCount == MAX_POLLS + 1, "R7 poll reads", rdCount, MAX_POLLS + 1);
    forceTog = 0;
    @(negedge clk);
    chk(errFlag == 1'b1, "R7 flag held", errFlag, 1);
    doRead(13'h0200, v);
    chk(errFlag == 1'b0, "R7 flag cleared by start", errFlag, 0);

    // buffer writes while busy are ignored
    loadBuf(0, 8'h5A);
    loadBuf(1, 8'h6B);
    nextBusy = 8;
    clrModel();
    @(negedge clk);
    pageAddr = 13'h0300; byteCount = 6'd2; startWr = 1'b1;
    @(negedge clk);
    startWr = 1'b0;
    bufWe = 1'b1; bufAddr = 6'd0; bufData = 8'hEE;
    repeat (4) @(negedge clk);
    bufAddr = 6'd1; bufData = 8'hDD;
    repeat (4) @(negedge clk);
    bufWe = 1'b0;
    waitDone("R10 write done");
    doRead(13'h0300, v);
    chk(v == 8'h5A, "R10 buffer locked", v, 8'h5A);

    // start in the same cycle as done
    @(negedge clk);
    pageAddr = 13'h0300; startRd = 1'b1;
    @(negedge clk);
    startRd = 1'b0;
    waitDone("R9 first done");
    chk(busy == 1'b0, "R9 busy low with done", busy, 0);
    pageAddr = 13'h0301; startRd = 1'b1;
    @(negedge clk);
    startRd = 1'b0;
    chk(busy == 1'b1, "R9 start taken with done", busy, 1);
    chk(done == 1'b0, "R9 done single pulse", done, 0);
    waitDone("R9 second done");
    chk(rdData == 8'h6B, "R8 read data", rdData, 8'h6B);

    chk(!clashSeen, "R3 strobe and bus conflicts", clashSeen, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule